// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog built around a wide up-counter and a matching period register. Software arms it by writing two key values to the control register in a fixed order. Once armed, the counter advances every clock cycle. If software does not service the watchdog in time, the counter reaches the period and the block raises a reset request to the rest of the chip.

Servicing uses the same pair of keys, written in the same order, and it clears the count. While the watchdog is armed, any control write that carries an unexpected key raises the reset request at once. A debug-halt input pauses the count unless software has set the free-run bit.

The request is a pulse of fixed length. After the pulse the block stays in a terminal state until its own reset. All state is reached through a 32-bit register bus that has a single write strobe and a combinational read path.

Top module: `wdk_top`

## Requirements
- R1: After reset, every readable register reads zero and `wd_rst_req` is low.
- R2: The key field is bits [31:16] of a control write. In the idle phase only key 0xA5C6 advances the block, to the pre-armed phase. In the pre-armed phase only key 0xDA7E advances it, to the armed phase. Any other key written in either phase is ignored.
- R3: A read of the control register (offset 0x00) returns the free-run bit in bit 0 and a phase code in bits [2:1]: 0 for idle, 1 for pre-armed, 2 for armed, 3 for fired. All other bits read zero.
- R4: In the armed phase the counter increments once per cycle. A count equal to or above the period fires the watchdog. With a count C and a period P at the arming write edge, `wd_rst_req` rises after clock edge P−C+1 that follows that edge.
- R5: A period of zero fires the watchdog on the first edge after the arming write.
- R6: In the armed phase, a control write whose key is not the next expected one (0xA5C6 first, then 0xDA7E) raises `wd_rst_req` at the edge of that write.
- R7: `wd_rst_req` stays high for exactly PULSE_LEN cycles (8 by default) and is then low.
- R8: Once fired, the block reports phase 3 and ignores all writes until `rst_n` is asserted.
- R9: In the armed phase, writing key 0xA5C6 and then key 0xDA7E clears the count at the edge of the second write, so that the timeout restarts from zero.
- R10: When the free-run bit is 0 and `dbg_halt` is high, the armed counter holds its value.
- R11: Every accepted control write loads bit 0 of the written data into the free-run bit. While that bit is 1, the counter keeps advancing during `dbg_halt`.
- R12: The counter is CNT_W bits wide (64 by default). The low word is read and written at 0x04 and the high word at 0x08. The period's low and high words sit at 0x0C and 0x10. The carry from the low word passes into the high word.
- R13: Writes to the count and period registers take effect only in the idle and pre-armed phases. In the armed phase they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| wd_rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume that a bus write lasts a single cycle and that `bus_addr` is stable while `bus_wr` is high. They also assume that `dbg_halt` changes only between clock edges. The bench drives every input on the falling edge and drops the strobe after one rising edge. It resets the block before each scenario, because the fired phase is terminal. Count preloads are kept small or sit just below a word carry, so that every timeout lands within a few dozen cycles.

// File: rtl/wdk_pkg.sv
// Shared definitions for the keyed watchdog: phases, keys and register offsets.
// Assumes byte offsets on an 8-bit or wider address.
package wdk_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_ARM   = 3'd2,
        PH_SVC   = 3'd3,
        PH_FIRED = 3'd4
    } wd_phase_e;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CNT_LO = 8'h04;
    localparam logic [7:0] OFS_CNT_HI = 8'h08;
    localparam logic [7:0] OFS_PRD_LO = 8'h0C;
    localparam logic [7:0] OFS_PRD_HI = 8'h10;

    // Software-visible phase code; the service sub-step reads as armed.
    function automatic logic [1:0] phase_code(wd_phase_e ph);
        case (ph)
            PH_IDLE:        return 2'd0;
            PH_PRE:         return 2'd1;
            PH_ARM, PH_SVC: return 2'd2;
            default:        return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/wdk_keyfsm.sv
// Key sequencer: follows the arming and service key order and decides when to fire.
// Assumes ctrl_wr is a one-cycle strobe. The fired phase is left only through rst_n.
module wdk_keyfsm
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [15:0] key,
    input  logic        free_in,
    input  logic        reached,
    output wd_phase_e   phase,
    output logic        free_run,
    output logic        fire,
    output logic        svc_clear
);
    wd_phase_e phase_nxt;

    // Next-phase decision; a timeout has priority over any key written in the same cycle.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE:  if (ctrl_wr && key == KEY_FIRST)  phase_nxt = PH_PRE;
            PH_PRE:   if (ctrl_wr && key == KEY_SECOND) phase_nxt = PH_ARM;
            PH_ARM: begin
                if (reached)      phase_nxt = PH_FIRED;
                else if (ctrl_wr) phase_nxt = (key == KEY_FIRST) ? PH_SVC : PH_FIRED;
            end
            PH_SVC: begin
                if (reached)      phase_nxt = PH_FIRED;
                else if (ctrl_wr) phase_nxt = (key == KEY_SECOND) ? PH_ARM : PH_FIRED;
            end
            default:              phase_nxt = PH_FIRED;
        endcase
    end

    assign fire      = (phase_nxt == PH_FIRED) && (phase != PH_FIRED);
    assign svc_clear = (phase == PH_SVC) && (phase_nxt == PH_ARM);

    // Phase register and free-run bit; writes have no effect once fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            free_run <= 1'b0;
        end else begin
            phase <= phase_nxt;
            if (ctrl_wr && phase != PH_FIRED) free_run <= free_in;
        end
    end
endmodule

// File: rtl/wdk_counter.sv
// Count and period registers, with the timeout compare.
// Assumes run and wr_ok are never both high; CNT_W lies between 33 and 64.
module wdk_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             wr_ok,
    input  logic             wr_cnt_lo,
    input  logic             wr_cnt_hi,
    input  logic             wr_prd_lo,
    input  logic             wr_prd_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd,
    output logic             reached
);
    localparam int HI_W = CNT_W - 32;

    // Counter: a service clear first, then counting, then software preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else if (wr_ok) begin
            if (wr_cnt_lo) cnt[31:0]       <= wdata;
            if (wr_cnt_hi) cnt[CNT_W-1:32] <= wdata[HI_W-1:0];
        end
    end

    // Period register, writable only while not armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd <= '0;
        end else if (wr_ok) begin
            if (wr_prd_lo) prd[31:0]       <= wdata;
            if (wr_prd_hi) prd[CNT_W-1:32] <= wdata[HI_W-1:0];
        end
    end

    assign reached = (cnt >= prd);
endmodule

// File: rtl/wdk_pulse.sv
// Reset-request stretcher: a single fire cycle becomes a pulse of LEN cycles.
// Assumes LEN >= 1.
module wdk_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] left;

    // Load the length on fire, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          left <= '0;
        else if (fire)       left <= CW'(LEN);
        else if (left != '0) left <= left - 1'b1;
    end

    assign req = (left != '0);
endmodule

// File: rtl/wdk_top.sv
// Keyed watchdog top: register decode, the read mux and wiring of the sequencer,
// counter and pulse stretcher. Assumes single-cycle writes and a stable address.
module wdk_top
    import wdk_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int PULSE_LEN = 8,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_halt,
    output logic              wd_rst_req
);
    localparam int HI_W = CNT_W - 32;

    wd_phase_e        phase;
    logic             free_run, fire, svc_clear, reached, armed, run, wr_ok;
    logic             ctrl_wr;
    logic [CNT_W-1:0] cnt_val, prd_val;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign armed   = (phase == PH_ARM) || (phase == PH_SVC);
    assign run     = armed && (!dbg_halt || free_run);
    assign wr_ok   = bus_wr && ((phase == PH_IDLE) || (phase == PH_PRE));

    wdk_keyfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .key       (bus_wdata[31:16]),
        .free_in   (bus_wdata[0]),
        .reached   (reached && armed),
        .phase     (phase),
        .free_run  (free_run),
        .fire      (fire),
        .svc_clear (svc_clear)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clear     (svc_clear),
        .wr_ok     (wr_ok),
        .wr_cnt_lo (bus_addr == ADDR_W'(OFS_CNT_LO)),
        .wr_cnt_hi (bus_addr == ADDR_W'(OFS_CNT_HI)),
        .wr_prd_lo (bus_addr == ADDR_W'(OFS_PRD_LO)),
        .wr_prd_hi (bus_addr == ADDR_W'(OFS_PRD_HI)),
        .wdata     (bus_wdata),
        .cnt       (cnt_val),
        .prd       (prd_val),
        .reached   (reached)
    );

    wdk_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .req   (wd_rst_req)
    );

    // Read mux; high words are zero-extended to 32 bits.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata[2:0]      = {phase_code(phase), free_run};
            ADDR_W'(OFS_CNT_LO): bus_rdata           = cnt_val[31:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata[HI_W-1:0] = cnt_val[CNT_W-1:32];
            ADDR_W'(OFS_PRD_LO): bus_rdata           = prd_val[31:0];
            ADDR_W'(OFS_PRD_HI): bus_rdata[HI_W-1:0] = prd_val[CNT_W-1:32];
            default:             bus_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/wdk_chk.sv
// Property checker for wdk_top, attached by bind. It assumes single-cycle writes.
module wdk_chk
    import wdk_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int PULSE_LEN = 8,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              dbg_halt,
    input logic              wd_rst_req,
    input wd_phase_e         phase,
    input logic              free_run,
    input logic [CNT_W-1:0]  cnt_val
);
    logic ctrl_wr, armed;
    int   hi_cycles;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign armed   = (phase == PH_ARM) || (phase == PH_SVC);

    // Counts every cycle of reset request since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cycles <= 0;
        else if (wd_rst_req) hi_cycles <= hi_cycles + 1;
    end

    // R1
    quiet_until_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FIRED) |-> !wd_rst_req);

    // R6
    bad_key_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctrl_wr && bus_wdata[31:16] != KEY_FIRST && bus_wdata[31:16] != KEY_SECOND)
        |=> wd_rst_req);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cycles <= PULSE_LEN);

    // R8
    fired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRED) |=> (phase == PH_FIRED));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dbg_halt && !free_run && !bus_wr) |=> $stable(cnt_val));
endmodule

bind wdk_top wdk_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .dbg_halt   (dbg_halt),
    .wd_rst_req (wd_rst_req),
    .phase      (phase),
    .free_run   (free_run),
    .cnt_val    (cnt_val)
);

// File: tb/test_wdk_top.sv
// Directed bench for wdk_top: one task per scenario, each checking its own results.
module test_wdk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        wd_rst_req;
    int          n_total = 0;
    int          n_fail = 0;

    localparam logic [31:0] K1 = 32'hA5C6_0000;
    localparam logic [31:0] K2 = 32'hDA7E_0000;

    always #4 clk = ~clk;

    wdk_top i_wdk_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dbg_halt   (dbg_halt),
        .wd_rst_req (wd_rst_req)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; dbg_halt = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 req", {31'b0, wd_rst_req}, 0);
        for (int a = 0; a <= 16; a += 4) begin
            rd(8'(a), v);
            check("R1 reg", v, 0);
        end
    endtask

    task automatic t_keys_idle();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'h1234_0000); rd(8'h00, v); check("R2 idle bad key", v, 0);
        wr(8'h00, K2);            rd(8'h00, v); check("R2 idle second key", v, 0);
        wr(8'h00, K1);            rd(8'h00, v); check("R3 pre code", v, 32'h2);
        wr(8'h00, 32'h5555_0000); rd(8'h00, v); check("R2 pre bad key", v, 32'h2);
        check("R2 no req", {31'b0, wd_rst_req}, 0);
        wr(8'h00, K2 | 1);        rd(8'h00, v); check("R3 armed code+free", v, 32'h5);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        do_reset();
        wr(8'h0C, 5);
        wr(8'h00, K1); wr(8'h00, K2);
        tick(5); check("R4 before", {31'b0, wd_rst_req}, 0);
        tick(1); check("R4 rise", {31'b0, wd_rst_req}, 1);
        tick(7); check("R7 still high", {31'b0, wd_rst_req}, 1);
        tick(1); check("R7 low after len", {31'b0, wd_rst_req}, 0);
        wr(8'h00, K1); wr(8'h0C, 50);
        rd(8'h00, v); check("R8 fired code", v, 32'h6);
        rd(8'h0C, v); check("R8 period frozen", v, 5);
        tick(3); check("R8 no second pulse", {31'b0, wd_rst_req}, 0);
    endtask

    task automatic t_zero_period();
        do_reset();
        wr(8'h00, K1); wr(8'h00, K2);
        check("R5 not at arm edge", {31'b0, wd_rst_req}, 0);
        tick(1); check("R5 fires next edge", {31'b0, wd_rst_req}, 1);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        do_reset();
        wr(8'h10, 1);
        wr(8'h00, K1); wr(8'h00, K2);
        tick(2); check("R6 quiet", {31'b0, wd_rst_req}, 0);
        wr(8'h00, 32'h1234_0000);
        check("R6 bad key immediate", {31'b0, wd_rst_req}, 1);
        do_reset();
        wr(8'h10, 1);
        wr(8'h00, K1); wr(8'h00, K2);
        wr(8'h00, K1); check("R6 first service key ok", {31'b0, wd_rst_req}, 0);
        wr(8'h00, K1); check("R6 wrong second key", {31'b0, wd_rst_req}, 1);
        rd(8'h00, v); check("R8 fired", v, 32'h6);
    endtask

    task automatic t_service();
        logic [31:0] v;
        do_reset();
        wr(8'h0C, 10);
        wr(8'h00, K1); wr(8'h00, K2);
        tick(6);
        wr(8'h00, K1); wr(8'h00, K2);
        rd(8'h04, v); check("R9 cleared", v, 0);
        tick(10); check("R9 no early fire", {31'b0, wd_rst_req}, 0);
        tick(1);  check("R9 fire after restart", {31'b0, wd_rst_req}, 1);
    endtask

    task automatic t_halt();
        logic [31:0] v, v2;
        do_reset();
        wr(8'h10, 1);
        wr(8'h00, K1); wr(8'h00, K2);
        dbg_halt = 1'b1;
        tick(1); rd(8'h04, v);
        tick(5); rd(8'h04, v2); check("R10 held", v2, v);
        dbg_halt = 1'b0;
        tick(3); rd(8'h04, v2); check("R10 resumes", v2, v + 3);
        wr(8'h00, K1 | 1); wr(8'h00, K2 | 1);
        dbg_halt = 1'b1;
        tick(4); rd(8'h04, v); check("R11 free-run counts", v, 4);
        dbg_halt = 1'b0;
    endtask

    task automatic t_carry();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h0C, 1); wr(8'h10, 1);
        wr(8'h00, K1); wr(8'h00, K2);
        tick(2);
        rd(8'h08, v); check("R12 high word", v, 1);
        rd(8'h04, v); check("R12 low word", v, 0);
        tick(1); check("R12 no fire yet", {31'b0, wd_rst_req}, 0);
        tick(1); check("R12 fire at wide period", {31'b0, wd_rst_req}, 1);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(8'h0C, 20);
        wr(8'h00, K1); wr(8'h00, K2);
        wr(8'h0C, 0);
        wr(8'h04, 32'h0000_FFFF);
        rd(8'h04, v); check("R13 count write ignored", v, 2);
        rd(8'h0C, v); check("R13 period write ignored", v, 20);
        tick(1); check("R13 no fire", {31'b0, wd_rst_req}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        t_reset();
        t_keys_idle();
        t_timeout();
        t_zero_period();
        t_bad_key();
        t_service();
        t_halt();
        t_carry();
        t_lock();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule